// File: doc/BRIEF.md
# Platform Device Enumeration Controller

This peripheral lets a host discover the devices fitted to a platform by stepping through a fixed table, one entry at a time. Each entry holds an identifier, an I/O window (base and size), a first interrupt line with a line count, and a name string of up to 16 bytes. The table is fixed at elaboration through parameters. The host accesses the block through a 32-bit word register interface. A single access is accepted in any cycle where `busValid` is high. Read data is combinational in that same cycle.

The host starts a scan with an init command. It then reads the operation register over and over. Each such read retires the current entry and moves to the next entry that has not yet been reported. A level interrupt stays high while entries remain. When the host gives a destination address, a byte-wide valid/ready write master copies the name of the current entry to consecutive memory addresses. Illegal accesses set a sticky error flag.

Name parameters are right-aligned strings. The first character sits in the most significant used byte, and the length of each entry is given separately.

Top module: `dev_enum_ctrl`

## Requirements
- R1: After reset, `intReq`, `errFlag` and `wrValid` are low, and a read of any field register returns 0.
- R2: Writing 0 to the operation register (byte offset 0x00) clears every reported flag and leaves no entry current, so all field registers read 0. It also raises `intReq`, because the table is never empty.
- R3: A read of offset 0x00 marks the current entry as reported, if there is one. It then selects the next unreported entry at a higher index, or the first unreported entry from index 0 if no entry was current. When such an entry exists, the read returns 0x08 in the same access.
- R4: Reported entries are skipped. Once a walk has completed, further operation reads return 0x00 until the next init.
- R5: When no unreported entry remains, the operation read returns 0x00, `intReq` goes low from the next cycle, and all field registers read 0.
- R6: The field registers of the current entry are: 0x08 name length (bits 4:0, with bit 31 = copy busy), 0x0C ID, 0x10 I/O base, 0x14 I/O size, 0x18 first IRQ and 0x1C IRQ count.
- R7: Writing an address A to offset 0x04 while an entry is current and no copy is running starts a copy. The copy emits name-length bytes on `wrData`, first character first, at addresses A+k. Each byte is held stable until `wrReady` accepts it. No terminating zero is written.
- R8: A write to 0x04 while no entry is current, or while a copy is running, has no effect.
- R9: Operation reads made during a copy still advance the walk, and the running copy keeps the name it latched.
- R10: An error sets the sticky `errFlag`, and only reset clears it. The errors are: a nonzero write to 0x00, a write to any read-only offset, a read of 0x04, an unaligned offset, and an offset above 0x1C. The erroneous access returns 0 and changes no other state.
- R11: An init issued in the middle of a walk restarts the walk from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| intReq | output | 1 | Entries remain to be reported |
| errFlag | output | 1 | Sticky access error |
| wrValid | output | 1 | Name byte write request |
| wrReady | input | 1 | Name byte accepted |
| wrAddr | output | 32 | Name byte address |
| wrData | output | 8 | Name byte |

## Verification
A corrupted reported-flag vector or pointer shows up in the very next operation read. It appears as a wrong 0x08/0x00 result or as an ID from the wrong entry, and `intReq` then drops one cycle too early or too late. A faulty copy engine appears as a wrong byte, order or address within the copy burst, or as a burst that is too long or too short. Because every field read is combinational, each advance is followed at once by a read of all six fields, which pins down the current entry in the same cycle.

// File: rtl/dev_enum_pkg.sv
package dev_enum_pkg;

  typedef enum logic [2:0] {
    SEL_OP,
    SEL_LEN,
    SEL_ID,
    SEL_BASE,
    SEL_SIZE,
    SEL_IRQ,
    SEL_CNT,
    SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic   doInit;
    logic   doAdvance;
    logic   doCopy;
    rdSel_e rdSel;
  } ctlStrobe_t;

  localparam logic [31:0] OP_ADD_DEV = 32'h0000_0008;
  localparam logic [31:0] OP_DONE    = 32'h0000_0000;
  localparam int          NAME_BYTES = 16;
  localparam int          LEN_W      = 5;

endpackage

// File: rtl/dev_enum_ctl.sv
module dev_enum_ctl
  import dev_enum_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output ctlStrobe_t        strobe,
  output logic              errFlag
);

  localparam int HI_W = ADDR_W - 5;

  logic       inMap;
  logic [2:0] wordIdx;
  logic       badAccess;

  assign inMap   = (busAddr[1:0] == 2'b00) && (busAddr[ADDR_W-1:5] == HI_W'(0));
  assign wordIdx = busAddr[4:2];

  always_comb begin
    strobe    = '{doInit: 1'b0, doAdvance: 1'b0, doCopy: 1'b0, rdSel: SEL_NONE};
    badAccess = 1'b0;
    if (busValid) begin
      if (!inMap) begin
        badAccess = 1'b1;
      end else if (busWrite) begin
        case (wordIdx)
          3'd0: begin
            if (busWdata == 32'd0) strobe.doInit = 1'b1;
            else                   badAccess     = 1'b1;
          end
          3'd1:    strobe.doCopy = 1'b1;
          default: badAccess     = 1'b1;
        endcase
      end else begin
        case (wordIdx)
          3'd0: begin
            strobe.doAdvance = 1'b1;
            strobe.rdSel     = SEL_OP;
          end
          3'd1:    badAccess    = 1'b1;
          3'd2:    strobe.rdSel = SEL_LEN;
          3'd3:    strobe.rdSel = SEL_ID;
          3'd4:    strobe.rdSel = SEL_BASE;
          3'd5:    strobe.rdSel = SEL_SIZE;
          3'd6:    strobe.rdSel = SEL_IRQ;
          default: strobe.rdSel = SEL_CNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          errFlag <= 1'b0;
    else if (badAccess) errFlag <= 1'b1;
  end

  // R10: the error flag never clears without reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R10: an erroneous access strobes nothing in the datapath
  p_err_no_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !inMap) |-> !(strobe.doInit || strobe.doAdvance || strobe.doCopy));

endmodule

// File: rtl/dev_enum_dp.sv
module dev_enum_dp
  import dev_enum_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter logic [NUM_DEV-1:0][31:0] DEV_ID = '0,
  parameter logic [NUM_DEV-1:0][31:0] DEV_BASE = '0,
  parameter logic [NUM_DEV-1:0][31:0] DEV_SIZE = '0,
  parameter logic [NUM_DEV-1:0][31:0] DEV_IRQ = '0,
  parameter logic [NUM_DEV-1:0][31:0] DEV_IRQCNT = '0,
  parameter logic [NUM_DEV-1:0][8*NAME_BYTES-1:0] DEV_NAME = '0,
  parameter logic [NUM_DEV-1:0][LEN_W-1:0] DEV_NAMELEN = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  strobe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        intReq,
  output logic        wrValid,
  input  logic        wrReady,
  output logic [31:0] wrAddr,
  output logic [7:0]  wrData
);

  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int POS_W = IDX_W + 1;

  logic [NUM_DEV-1:0] reported;
  logic               curValid;
  logic [IDX_W-1:0]   curIdx;
  logic               irqQ;

  logic [NUM_DEV-1:0] markRep;
  logic [POS_W-1:0]   startPos;
  logic               hit;
  logic [IDX_W-1:0]   hitIdx;

  // priority search: lowest unreported index at or above startPos
  always_comb begin
    markRep = reported;
    if (curValid) markRep[curIdx] = 1'b1;
    startPos = curValid ? (POS_W'(curIdx) + POS_W'(1)) : POS_W'(0);
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (!hit && !markRep[i] && (POS_W'(i) >= startPos)) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reported <= '0;
      curValid <= 1'b0;
      curIdx   <= '0;
      irqQ     <= 1'b0;
    end else if (strobe.doInit) begin
      reported <= '0;
      curValid <= 1'b0;
      curIdx   <= '0;
      irqQ     <= (NUM_DEV > 0);
    end else if (strobe.doAdvance) begin
      reported <= markRep;
      curValid <= hit;
      curIdx   <= hit ? hitIdx : '0;
      if (!hit) irqQ <= 1'b0;
    end
  end

  assign intReq = irqQ;

  // current entry fields, zero when no entry is current
  logic [31:0]      curId, curBase, curSize, curIrq, curIrqCnt;
  logic [LEN_W-1:0] curLen;
  logic [8*NAME_BYTES-1:0] curName;

  always_comb begin
    curId = '0; curBase = '0; curSize = '0; curIrq = '0; curIrqCnt = '0;
    curLen = '0; curName = '0;
    if (curValid) begin
      curId     = DEV_ID[curIdx];
      curBase   = DEV_BASE[curIdx];
      curSize   = DEV_SIZE[curIdx];
      curIrq    = DEV_IRQ[curIdx];
      curIrqCnt = DEV_IRQCNT[curIdx];
      curLen    = DEV_NAMELEN[curIdx];
      curName   = DEV_NAME[curIdx];
    end
  end

  // name copy engine
  logic                    cpBusy;
  logic [31:0]             cpAddr;
  logic [LEN_W-1:0]        cpCnt;
  logic [LEN_W-1:0]        cpLen;
  logic [8*NAME_BYTES-1:0] cpName;
  logic [LEN_W-1:0]        byteSel;
  logic                    cpStart;

  assign cpStart = strobe.doCopy && curValid && !cpBusy && (curLen != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpBusy <= 1'b0;
      cpAddr <= '0;
      cpCnt  <= '0;
      cpLen  <= '0;
      cpName <= '0;
    end else if (cpStart) begin
      cpBusy <= 1'b1;
      cpAddr <= busWdata;
      cpCnt  <= '0;
      cpLen  <= curLen;
      cpName <= curName;
    end else if (cpBusy && wrReady) begin
      cpCnt <= cpCnt + LEN_W'(1);
      if (cpCnt == cpLen - LEN_W'(1)) cpBusy <= 1'b0;
    end
  end

  assign byteSel = cpLen - LEN_W'(1) - cpCnt;
  assign wrValid = cpBusy;
  assign wrAddr  = cpAddr + 32'(cpCnt);
  assign wrData  = 8'(cpName >> {byteSel, 3'b000});

  always_comb begin
    case (strobe.rdSel)
      SEL_OP:   busRdata = hit ? OP_ADD_DEV : OP_DONE;
      SEL_LEN:  busRdata = {cpBusy, {(31-LEN_W){1'b0}}, curLen};
      SEL_ID:   busRdata = curId;
      SEL_BASE: busRdata = curBase;
      SEL_SIZE: busRdata = curSize;
      SEL_IRQ:  busRdata = curIrq;
      SEL_CNT:  busRdata = curIrqCnt;
      default:  busRdata = '0;
    endcase
  end

  // R4: the pointer never rests on a reported entry
  p_cur_unreported_r4: assert property (@(posedge clk) disable iff (!rstN)
    curValid |-> !reported[curIdx]);

  // R5: an advance that finds nothing drops the interrupt
  p_done_irq_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doAdvance && !strobe.doInit && !hit) |=> !intReq);

  // R2: init raises the interrupt
  p_init_irq_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doInit |=> (intReq && !curValid));

  // R7: a stalled byte holds address and data
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));

  // R7: the byte counter stays inside the latched length
  p_copy_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (cpCnt < cpLen));

endmodule

// File: rtl/dev_enum_ctrl.sv
module dev_enum_ctrl
  import dev_enum_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_DEV = 4,
  parameter logic [NUM_DEV-1:0][31:0] DEV_ID =
    {32'h0000_0004, 32'h0000_0003, 32'h0000_0002, 32'h0000_0001},
  parameter logic [NUM_DEV-1:0][31:0] DEV_BASE =
    {32'h4000_3000, 32'h4000_2000, 32'h4000_1000, 32'h4000_0000},
  parameter logic [NUM_DEV-1:0][31:0] DEV_SIZE =
    {32'h0000_1000, 32'h0000_1000, 32'h0000_1000, 32'h0000_1000},
  parameter logic [NUM_DEV-1:0][31:0] DEV_IRQ =
    {32'd8, 32'd6, 32'd5, 32'd4},
  parameter logic [NUM_DEV-1:0][31:0] DEV_IRQCNT =
    {32'd1, 32'd2, 32'd1, 32'd1},
  parameter logic [NUM_DEV-1:0][8*NAME_BYTES-1:0] DEV_NAME =
    {128'("rtc"), 128'("gpio"), 128'("timer"), 128'("serial")},
  parameter logic [NUM_DEV-1:0][LEN_W-1:0] DEV_NAMELEN =
    {5'd3, 5'd4, 5'd5, 5'd6}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              intReq,
  output logic              errFlag,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [31:0]       wrAddr,
  output logic [7:0]        wrData
);

  ctlStrobe_t strobe;

  dev_enum_ctl #(.ADDR_W(ADDR_W)) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobe   (strobe),
    .errFlag  (errFlag)
  );

  dev_enum_dp #(
    .NUM_DEV     (NUM_DEV),
    .DEV_ID      (DEV_ID),
    .DEV_BASE    (DEV_BASE),
    .DEV_SIZE    (DEV_SIZE),
    .DEV_IRQ     (DEV_IRQ),
    .DEV_IRQCNT  (DEV_IRQCNT),
    .DEV_NAME    (DEV_NAME),
    .DEV_NAMELEN (DEV_NAMELEN)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .intReq   (intReq),
    .wrValid  (wrValid),
    .wrReady  (wrReady),
    .wrAddr   (wrAddr),
    .wrData   (wrData)
  );

endmodule

// File: tb/dev_enum_ctrl_tb_top.sv
module dev_enum_ctrl_tb_top;

  localparam logic [3:0][31:0] T_ID =
    {32'h0000_0104, 32'h0000_0A03, 32'h0000_0002, 32'h0000_0051};
  localparam logic [3:0][31:0] T_BASE =
    {32'h1000_8000, 32'h1000_4000, 32'h1000_3000, 32'h1000_2000};
  localparam logic [3:0][31:0] T_SIZE =
    {32'h0000_0040, 32'h0000_2000, 32'h0000_0100, 32'h0000_1000};
  localparam logic [3:0][31:0] T_IRQ =
    {32'd9, 32'd6, 32'd4, 32'd3};
  localparam logic [3:0][31:0] T_CNT =
    {32'd0, 32'd3, 32'd2, 32'd1};
  localparam logic [3:0][127:0] T_NAME =
    {128'("audio_codec_main"), 128'("nand_flash_ctl"), 128'("timer0"), 128'("uart")};
  localparam logic [3:0][4:0] T_LEN = {5'd16, 5'd14, 5'd6, 5'd4};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        intReq, errFlag, wrValid;
  logic        wrReady = 1'b1;
  logic [31:0] wrAddr;
  logic [7:0]  wrData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int capCount = 0;
  logic [7:0]  capData [64];
  logic [31:0] capAddr [64];

  always #10 clk = ~clk;

  dev_enum_ctrl #(
    .ADDR_W(8), .NUM_DEV(4), .DEV_ID(T_ID), .DEV_BASE(T_BASE), .DEV_SIZE(T_SIZE),
    .DEV_IRQ(T_IRQ), .DEV_IRQCNT(T_CNT), .DEV_NAME(T_NAME), .DEV_NAMELEN(T_LEN)
  ) dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .intReq(intReq), .errFlag(errFlag), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wrValid && wrReady && capCount < 64) begin
      capData[capCount] <= wrData;
      capAddr[capCount] <= wrAddr;
      capCount <= capCount + 1;
    end
  end

  // stalls on the byte master
  always @(negedge clk) wrReady <= (cyc % 3) != 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #2 d = busRdata;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic checkFields(input string req, input bit valid, input int e);
    logic [31:0] d;
    busRd(8'h08, d); chk(req, d & 32'h7FFF_FFFF, valid ? 32'(T_LEN[e]) : 0);
    busRd(8'h0C, d); chk(req, d, valid ? T_ID[e] : 0);
    busRd(8'h10, d); chk(req, d, valid ? T_BASE[e] : 0);
    busRd(8'h14, d); chk(req, d, valid ? T_SIZE[e] : 0);
    busRd(8'h18, d); chk(req, d, valid ? T_IRQ[e] : 0);
    busRd(8'h1C, d); chk(req, d, valid ? T_CNT[e] : 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tReset();
    logic [31:0] d;
    doReset();
    chk("R1 intReq", 32'(intReq), 0);
    chk("R1 errFlag", 32'(errFlag), 0);
    chk("R1 wrValid", 32'(wrValid), 0);
    busRd(8'h0C, d); chk("R1 id", d, 0);
  endtask

  task automatic tWalk();
    logic [31:0] d;
    busWr(8'h00, 0);
    chk("R2 intReq", 32'(intReq), 1);
    checkFields("R2 none", 1'b0, 0);
    for (int e = 0; e < 4; e++) begin
      busRd(8'h00, d); chk("R3 op", d, 32'h8);
      checkFields("R6 fields", 1'b1, e);
      chk("R3 intReq held", 32'(intReq), 1);
    end
    busRd(8'h00, d); chk("R5 op done", d, 0);
    chk("R5 intReq", 32'(intReq), 0);
    checkFields("R5 none", 1'b0, 0);
    busRd(8'h00, d); chk("R4 skip reported", d, 0);
    chk("R4 intReq", 32'(intReq), 0);
  endtask

  task automatic tRestart();
    logic [31:0] d;
    busWr(8'h00, 0);
    busRd(8'h00, d);
    busRd(8'h00, d);
    busRd(8'h0C, d); chk("R3 second", d, T_ID[1]);
    busWr(8'h00, 0);
    busRd(8'h00, d); chk("R11 op", d, 32'h8);
    busRd(8'h0C, d); chk("R11 first again", d, T_ID[0]);
    chk("R11 intReq", 32'(intReq), 1);
  endtask

  task automatic waitCopy();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!wrValid) break;
    end
  endtask

  task automatic checkCopy(input string req, input int e, input logic [31:0] base, input int from);
    chk({req, " count"}, 32'(capCount - from), 32'(T_LEN[e]));
    for (int k = 0; k < int'(T_LEN[e]); k++) begin
      chk({req, " byte"}, 32'(capData[from+k]), 32'(T_NAME[e][8*(int'(T_LEN[e])-1-k) +: 8]));
      chk({req, " addr"}, capAddr[from+k], base + 32'(k));
    end
  endtask

  task automatic tCopy();
    logic [31:0] d;
    int from;
    busWr(8'h00, 0);
    for (int i = 0; i < 3; i++) busRd(8'h00, d);
    from = capCount;
    busWr(8'h04, 32'h8000_0100);
    busRd(8'h08, d); chk("R6 busy bit", d, 32'h8000_000E);
    busWr(8'h04, 32'h9000_0000);          // R8: ignored while busy
    busRd(8'h00, d); chk("R9 op in copy", d, 32'h8);
    busRd(8'h0C, d); chk("R9 advanced", d, T_ID[3]);
    waitCopy();
    repeat (3) @(negedge clk);
    checkCopy("R7/R9 copy", 2, 32'h8000_0100, from);
    busRd(8'h08, d); chk("R6 busy clear", d, 32'h10);
    from = capCount;
    busWr(8'h04, 32'h0000_0200);
    waitCopy();
    repeat (3) @(negedge clk);
    checkCopy("R7 full name", 3, 32'h0000_0200, from);
    busRd(8'h00, d); chk("R5 done", d, 0);
    from = capCount;
    busWr(8'h04, 32'h0000_0300);
    repeat (5) @(negedge clk);
    chk("R8 no current wrValid", 32'(wrValid), 0);
    chk("R8 no bytes", 32'(capCount - from), 0);
  endtask

  task automatic tErrors();
    logic [31:0] d;
    busWr(8'h00, 0);
    busRd(8'h00, d);
    chk("R10 pre", 32'(errFlag), 0);
    busWr(8'h00, 32'h5);
    chk("R10 bad op", 32'(errFlag), 1);
    chk("R10 irq kept", 32'(intReq), 1);
    busRd(8'h0C, d); chk("R10 entry kept", d, T_ID[0]);
    busRd(8'h04, d); chk("R10 wo read", d, 0);
    busRd(8'h20, d); chk("R10 out of map", d, 0);
    busRd(8'h0D, d); chk("R10 unaligned", d, 0);
    busWr(8'h0C, 32'h1);
    busRd(8'h10, d); chk("R10 ro write", d, T_BASE[0]);
    repeat (4) @(negedge clk);
    chk("R10 sticky", 32'(errFlag), 1);
    doReset();
    chk("R10 reset clears", 32'(errFlag), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tWalk();
    tRestart();
    tCopy();
    tErrors();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule